// File: doc/BRIEF.md
# Dual Timer/Counter Unit

This block holds two 16-bit timer/counters, Timer0 and Timer1. Each is built from a low byte and a high byte. A counter advances on either an internal count strobe or on falling edges of its own external count pin. Counting can be gated by an external active-low request pin, so the width of a pulse on that pin can be measured. A shared mode register picks, for each counter, one of four layouts: a 13-bit counter, a 16-bit counter, an 8-bit counter with automatic reload, and a split layout. A shared control register holds the run bits and the two overflow flags.

Software reaches all six registers through a byte-wide register bus. The bus has a write strobe and a combinational read port. Each overflow flag is set by hardware when its counter wraps. It is cleared when the interrupt controller pulses the matching acknowledge input, or when software writes the control register.

Top module: `dual_timer_counter`

## Requirements
- R1: Out of reset, all six registers read 0x00. The control register is at address 0x88, the mode register at 0x89, the low bytes at 0x8A (Timer0) and 0x8B (Timer1), and the high bytes at 0x8C (Timer0) and 0x8D (Timer1). All six can be written and read back.
- R2: Mode register bits [7:4] configure Timer1 and bits [3:0] configure Timer0. Within each nibble, bit 3 is the gate enable. A counter may advance only while its run bit is 1 (control bit 4 for Timer0, bit 6 for Timer1). When the gate enable is set, the matching request pin (`int0_n` / `int1_n`) must also be high.
- R3: With nibble bit 2 clear, an enabled counter advances once per cycle in which `tick` is high. With it set, the count pin is sampled in each `tick` cycle, and the counter advances in a `tick` cycle where the previous sample was 1 and the current pin value is 0.
- R4: Layout 00 (nibble bits [1:0]) is a 13-bit counter. Low bits [4:0] carry into the 8-bit high byte, and low bits [7:5] keep their value. Overflow happens when 0x1FFF advances to 0.
- R5: Layout 01 is a 16-bit counter that overflows when 0xFFFF advances to 0.
- R6: Layout 10 counts in the low byte only. When the low byte advances from 0xFF, it takes the high-byte value and signals an overflow.
- R7: Timer0 in layout 11 splits in two. Its low byte is an 8-bit counter under Timer0's own controls, and its wrap sets flag bit 5. Its high byte counts `tick` while control bit 6 is 1, and its wrap sets flag bit 7.
- R8: Timer1 in layout 11 holds its count.
- R9: Flags are control bits 5 (Timer0) and 7 (Timer1), and also appear on `tf0`/`tf1`. A flag is set by an overflow, and `ack0`/`ack1` clears it. A same-cycle overflow beats both a software write and an acknowledge. A software write beats an acknowledge.
- R10: A bus write to a count byte takes effect, replacing any increment of that byte in the same cycle.
- R11: While Timer0 is in layout 11, Timer1 still counts in its own layout, but its overflow does not set flag bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Internal count strobe and pin sample strobe |
| t0_pin | input | 1 | Timer0 external count pin |
| t1_pin | input | 1 | Timer1 external count pin |
| int0_n | input | 1 | Timer0 gate request pin |
| int1_n | input | 1 | Timer1 gate request pin |
| ack0 | input | 1 | Timer0 interrupt acknowledge |
| ack1 | input | 1 | Timer1 interrupt acknowledge |
| sfr_addr | input | 8 | Register address |
| sfr_wr | input | 1 | Write strobe |
| sfr_wdata | input | 8 | Write data |
| sfr_rdata | output | 8 | Read data of the addressed register |
| tf0 | output | 1 | Timer0 overflow flag |
| tf1 | output | 1 | Timer1 overflow flag |

## Verification
The embedded properties check the following on every cycle:
- an overflow always raises its flag;
- an acknowledge clears the flag when nothing competes with it;
- bus writes land in the count bytes;
- the reload from the high byte in layout 10;
- the stall of Timer1 in layout 11;
- the idle hold of a counter that is not enabled;
- the untouched top bits of the 13-bit layout.

Several behaviours are shown only by the bench's reference model, which compares every register and flag against the design on every clock during the scenario phases:
- carry chains across all layouts;
- falling-edge detection on the count pins;
- gating by the request pins;
- the split layout's cross-use of the Timer1 run bit and flag;
- the three-way flag priority under random traffic.

// File: rtl/dual_timer_counter.sv
module dual_timer_counter #(
  parameter logic [7:0] ADDR_CTRL = 8'h88,
  parameter logic [7:0] ADDR_MODE = 8'h89,
  parameter logic [7:0] ADDR_LO0  = 8'h8A,
  parameter logic [7:0] ADDR_LO1  = 8'h8B,
  parameter logic [7:0] ADDR_HI0  = 8'h8C,
  parameter logic [7:0] ADDR_HI1  = 8'h8D
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       t0_pin,
  input  logic       t1_pin,
  input  logic       int0_n,
  input  logic       int1_n,
  input  logic       ack0,
  input  logic       ack1,
  input  logic [7:0] sfr_addr,
  input  logic       sfr_wr,
  input  logic [7:0] sfr_wdata,
  output logic [7:0] sfr_rdata,
  output logic       tf0,
  output logic       tf1
);

  logic [7:0] mode_q, ctrl_q, lo0_q, hi0_q, lo1_q, hi1_q;
  logic       smp0_q, smp1_q;

  function automatic logic [16:0] advance(input logic [1:0] md, input logic [7:0] lo,
                                          input logic [7:0] hi, input logic en);
    logic [16:0] r;
    r = {1'b0, hi, lo};
    if (en) begin
      case (md)
        2'b00: begin
          if (lo[4:0] == 5'h1f) begin
            r[4:0]  = 5'd0;
            r[15:8] = hi + 8'd1;
            r[16]   = (hi == 8'hff);
          end else begin
            r[4:0] = lo[4:0] + 5'd1;
          end
        end
        2'b01:   r = {1'b0, hi, lo} + 17'd1;
        2'b10: begin
          if (lo == 8'hff) begin
            r[7:0] = hi;
            r[16]  = 1'b1;
          end else begin
            r[7:0] = lo + 8'd1;
          end
        end
        default: r = {1'b0, hi, lo};
      endcase
    end
    return r;
  endfunction

  wire wr_ctrl = sfr_wr && (sfr_addr == ADDR_CTRL);
  wire wr_mode = sfr_wr && (sfr_addr == ADDR_MODE);
  wire wr_lo0  = sfr_wr && (sfr_addr == ADDR_LO0);
  wire wr_lo1  = sfr_wr && (sfr_addr == ADDR_LO1);
  wire wr_hi0  = sfr_wr && (sfr_addr == ADDR_HI0);
  wire wr_hi1  = sfr_wr && (sfr_addr == ADDR_HI1);

  wire [1:0] md0   = mode_q[1:0];
  wire [1:0] md1   = mode_q[5:4];
  wire       split = (md0 == 2'b11);

  wire fall0 = tick && smp0_q && !t0_pin;
  wire fall1 = tick && smp1_q && !t1_pin;
  wire run0  = ctrl_q[4] && (!mode_q[3] || int0_n);
  wire run1  = ctrl_q[6] && (!mode_q[7] || int1_n);
  wire inc0  = run0 && (mode_q[2] ? fall0 : tick);
  wire inc1  = run1 && (mode_q[6] ? fall1 : tick);
  wire inc_h0 = split && ctrl_q[6] && tick;

  wire [16:0] adv0 = advance(md0, lo0_q, hi0_q, inc0);
  wire [16:0] adv1 = advance(md1, lo1_q, hi1_q, inc1);

  wire [7:0] lo0_nx = split ? (inc0 ? lo0_q + 8'd1 : lo0_q) : adv0[7:0];
  wire [7:0] hi0_nx = split ? (inc_h0 ? hi0_q + 8'd1 : hi0_q) : adv0[15:8];
  wire       set0   = split ? (inc0 && lo0_q == 8'hff) : adv0[16];
  wire       set1   = split ? (inc_h0 && hi0_q == 8'hff) : adv1[16];

  logic [7:0] ctrl_nx;
  always_comb begin
    ctrl_nx = ctrl_q;
    if (wr_ctrl) ctrl_nx = sfr_wdata;
    else begin
      if (ack0) ctrl_nx[5] = 1'b0;
      if (ack1) ctrl_nx[7] = 1'b0;
    end
    if (set0) ctrl_nx[5] = 1'b1;
    if (set1) ctrl_nx[7] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 8'h00;
      ctrl_q <= 8'h00;
      lo0_q  <= 8'h00;
      hi0_q  <= 8'h00;
      lo1_q  <= 8'h00;
      hi1_q  <= 8'h00;
      smp0_q <= 1'b0;
      smp1_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_nx;
      mode_q <= wr_mode ? sfr_wdata : mode_q;
      lo0_q  <= wr_lo0 ? sfr_wdata : lo0_nx;
      hi0_q  <= wr_hi0 ? sfr_wdata : hi0_nx;
      lo1_q  <= wr_lo1 ? sfr_wdata : adv1[7:0];
      hi1_q  <= wr_hi1 ? sfr_wdata : adv1[15:8];
      if (tick) begin
        smp0_q <= t0_pin;
        smp1_q <= t1_pin;
      end
    end
  end

  always_comb begin
    case (sfr_addr)
      ADDR_CTRL: sfr_rdata = ctrl_q;
      ADDR_MODE: sfr_rdata = mode_q;
      ADDR_LO0:  sfr_rdata = lo0_q;
      ADDR_LO1:  sfr_rdata = lo1_q;
      ADDR_HI0:  sfr_rdata = hi0_q;
      ADDR_HI1:  sfr_rdata = hi1_q;
      default:   sfr_rdata = 8'h00;
    endcase
  end

  assign tf0 = ctrl_q[5];
  assign tf1 = ctrl_q[7];

  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run0 && !split && !wr_lo0 && !wr_hi0) |=> $stable({hi0_q, lo0_q}));
  p_top_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (md0 == 2'b00 && !wr_lo0) |=> (lo0_q[7:5] == $past(lo0_q[7:5])));
  p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (md0 == 2'b10 && inc0 && lo0_q == 8'hff && !wr_lo0) |=> (lo0_q == $past(hi0_q)));
  p_split_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_h0 && !wr_hi0) |=> (hi0_q == $past(hi0_q) + 8'd1));
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (md1 == 2'b11 && !wr_lo1 && !wr_hi1) |=> $stable({hi1_q, lo1_q}));
  p_hw_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    set0 |=> tf0);
  p_ack_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack1 && !wr_ctrl && !set1) |=> !tf1);
  p_write_lo_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo1 |=> (lo1_q == $past(sfr_wdata)));

endmodule

// File: tb/dual_timer_counter_test.sv
module dual_timer_counter_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, t0_pin = 1'b0, t1_pin = 1'b0, int0_n = 1'b1, int1_n = 1'b1;
  logic ack0 = 1'b0, ack1 = 1'b0, sfr_wr = 1'b0;
  logic [7:0] sfr_addr = 8'h88, sfr_wdata = 8'h00;
  logic [7:0] sfr_rdata;
  logic tf0, tf1;

  always #2.5 clk = ~clk;

  dual_timer_counter uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .t0_pin(t0_pin), .t1_pin(t1_pin),
    .int0_n(int0_n), .int1_n(int1_n), .ack0(ack0), .ack1(ack1),
    .sfr_addr(sfr_addr), .sfr_wr(sfr_wr), .sfr_wdata(sfr_wdata),
    .sfr_rdata(sfr_rdata), .tf0(tf0), .tf1(tf1));

  int compared = 0, mismatched = 0, cycles = 0;
  string tag = "R1";
  bit [7:0] m_mode, m_ctrl, m_lo0, m_hi0, m_lo1, m_hi1;
  bit m_s0, m_s1;

  task automatic chk(input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  function automatic bit [7:0] m_read(input bit [7:0] a);
    case (a)
      8'h88: return m_ctrl;
      8'h89: return m_mode;
      8'h8A: return m_lo0;
      8'h8B: return m_lo1;
      8'h8C: return m_hi0;
      8'h8D: return m_hi1;
      default: return 8'h00;
    endcase
  endfunction

  task automatic count(input bit [1:0] md, inout bit [7:0] lo, inout bit [7:0] hi,
                       input bit en, output bit ov);
    int v;
    ov = 0;
    if (!en) return;
    case (md)
      2'd0: begin
        v = int'(hi) * 32 + int'(lo % 32) + 1;
        if (v == 8192) begin v = 0; ov = 1; end
        lo = 8'((lo / 32) * 32 + v % 32);
        hi = 8'(v / 32);
      end
      2'd1: begin
        v = int'(hi) * 256 + int'(lo) + 1;
        if (v == 65536) begin v = 0; ov = 1; end
        lo = 8'(v % 256);
        hi = 8'(v / 256);
      end
      2'd2: begin
        if (lo == 255) begin lo = hi; ov = 1; end
        else lo = lo + 8'd1;
      end
      default: ;
    endcase
  endtask

  task automatic m_step();
    bit f0, f1, r0, r1, i0, i1, s0, s1, o1, old_tf0, old_tf1;
    f0 = tick && m_s0 && !t0_pin;
    f1 = tick && m_s1 && !t1_pin;
    if (tick) begin m_s0 = t0_pin; m_s1 = t1_pin; end
    r0 = m_ctrl[4] && (!m_mode[3] || int0_n);
    r1 = m_ctrl[6] && (!m_mode[7] || int1_n);
    i0 = r0 && (m_mode[2] ? f0 : tick);
    i1 = r1 && (m_mode[6] ? f1 : tick);
    s0 = 0; s1 = 0;
    if (m_mode[1:0] == 2'd3) begin
      if (i0) begin m_lo0 = m_lo0 + 8'd1; s0 = (m_lo0 == 0); end
      if (m_ctrl[6] && tick) begin m_hi0 = m_hi0 + 8'd1; s1 = (m_hi0 == 0); end
    end else count(m_mode[1:0], m_lo0, m_hi0, i0, s0);
    if (m_mode[5:4] != 2'd3) begin
      count(m_mode[5:4], m_lo1, m_hi1, i1, o1);
      if (m_mode[1:0] != 2'd3) s1 = o1;
    end
    old_tf0 = m_ctrl[5];
    old_tf1 = m_ctrl[7];
    if (sfr_wr) begin
      case (sfr_addr)
        8'h88: m_ctrl = sfr_wdata;
        8'h89: m_mode = sfr_wdata;
        8'h8A: m_lo0 = sfr_wdata;
        8'h8B: m_lo1 = sfr_wdata;
        8'h8C: m_hi0 = sfr_wdata;
        8'h8D: m_hi1 = sfr_wdata;
        default: ;
      endcase
    end
    if (!(sfr_wr && sfr_addr == 8'h88)) begin
      m_ctrl[5] = ack0 ? 1'b0 : old_tf0;
      m_ctrl[7] = ack1 ? 1'b0 : old_tf1;
    end
    if (s0) m_ctrl[5] = 1'b1;
    if (s1) m_ctrl[7] = 1'b1;
  endtask

  always @(negedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_mode = 0; m_ctrl = 0; m_lo0 = 0; m_hi0 = 0; m_lo1 = 0; m_hi1 = 0; m_s0 = 0; m_s1 = 0;
    end
    chk($sformatf("rdata@%0h", sfr_addr), sfr_rdata, m_read(sfr_addr));
    chk("tf0", tf0, m_ctrl[5]);
    chk("tf1", tf1, m_ctrl[7]);
    if (rst_n) m_step();
    if (cycles > 150000) begin
      compared++; mismatched++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      finish_run();
    end
  end

  int rd_idx = 0;

  task automatic nxt();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input bit [7:0] a, input bit [7:0] d);
    sfr_addr = a; sfr_wdata = d; sfr_wr = 1;
    nxt();
    sfr_wr = 0;
  endtask

  task automatic run(input int n, input int tick_pct, input bit pins, input bit gates, input bit acks);
    for (int i = 0; i < n; i++) begin
      tick = ($urandom % 100) < tick_pct;
      if (pins) begin t0_pin = $urandom % 2; t1_pin = $urandom % 2; end
      if (gates) begin int0_n = $urandom % 2; int1_n = $urandom % 2; end
      ack0 = acks && ($urandom % 8 == 0);
      ack1 = acks && ($urandom % 8 == 0);
      sfr_addr = 8'h88 + 8'(rd_idx % 6);
      rd_idx++;
      nxt();
    end
    ack0 = 0; ack1 = 0;
  endtask

  initial begin
    repeat (3) nxt();
    tag = "R1";
    run(12, 50, 1, 1, 0);
    rst_n = 1;
    run(12, 50, 1, 1, 0);
    wr(8'h8A, 8'h5A); wr(8'h8D, 8'hC3); wr(8'h89, 8'h00);
    run(8, 0, 0, 0, 0);

    tag = "R2";
    wr(8'h89, 8'h99); wr(8'h8A, 8'hF0); wr(8'h8C, 8'hFF); wr(8'h88, 8'h50);
    run(600, 100, 0, 1, 1);
    wr(8'h89, 8'h11); wr(8'h88, 8'h00);
    run(40, 100, 0, 1, 0);

    tag = "R3";
    wr(8'h89, 8'h55); wr(8'h88, 8'h50); wr(8'h8A, 8'hF8); wr(8'h8C, 8'hFF);
    run(800, 60, 1, 0, 1);

    tag = "R4";
    wr(8'h89, 8'h00); wr(8'h8A, 8'hE8); wr(8'h8C, 8'hFF); wr(8'h8B, 8'h1A); wr(8'h8D, 8'hFF);
    wr(8'h88, 8'h50);
    run(700, 100, 0, 0, 1);

    tag = "R5";
    wr(8'h89, 8'h11); wr(8'h8A, 8'hF0); wr(8'h8C, 8'hFF); wr(8'h8B, 8'hE0); wr(8'h8D, 8'hFF);
    run(400, 100, 0, 0, 1);

    tag = "R6";
    wr(8'h89, 8'h22); wr(8'h8C, 8'hF0); wr(8'h8D, 8'hFA); wr(8'h8A, 8'hFE);
    run(400, 80, 0, 0, 1);

    tag = "R7 R11";
    wr(8'h89, 8'h13); wr(8'h8A, 8'hF0); wr(8'h8C, 8'hF8); wr(8'h8B, 8'hF0); wr(8'h8D, 8'hFF);
    wr(8'h88, 8'h50);
    run(600, 100, 0, 0, 1);

    tag = "R8";
    wr(8'h89, 8'h31); wr(8'h8B, 8'h77); wr(8'h8D, 8'h66);
    run(300, 100, 1, 1, 1);

    tag = "R9 R10";
    for (int k = 0; k < 4000; k++) begin
      tick = $urandom % 2; t0_pin = $urandom % 2; t1_pin = $urandom % 2;
      int0_n = $urandom % 2; int1_n = $urandom % 2;
      ack0 = ($urandom % 4 == 0); ack1 = ($urandom % 4 == 0);
      sfr_addr = 8'h88 + 8'($urandom % 6);
      sfr_wr = ($urandom % 5 == 0);
      sfr_wdata = ($urandom % 3 == 0) ? 8'hFF : 8'($urandom);
      if (sfr_wr && sfr_addr == 8'h88) sfr_wdata[6] = 1'b1;
      if (sfr_wr && sfr_addr == 8'h88) sfr_wdata[4] = 1'b1;
      nxt();
    end
    sfr_wr = 0; ack0 = 0; ack1 = 0;
    run(20, 50, 1, 1, 0);
    finish_run();
  end
endmodule